// File: doc/BRIEF.md
# Serial Port Host Register Block

This block is the processor-facing register set of a serial port. A host reaches it through a simple single-cycle register bus with a byte address. Received characters come in on a valid/ready byte stream and queue in a receive buffer. Writing the data register sends the low byte out on a transmit byte stream as a one-cycle pulse. The block also holds the baud divisors, line and control settings, the level-select and DMA-control words as plain storage, a flag word, and interrupt raw, mask and masked registers. The flag word and the interrupt registers drive one combined interrupt line.

The receive buffer holds 16 entries when the queue-enable bit of the line-control register (bit 4) is set. When that bit is clear the buffer acts as a single holding slot. Occupancy is tracked by a three-state machine. RX_EMPTY holds no entry. RX_HOLDING holds at least one entry and fewer than the depth. RX_FULL holds exactly the depth. A push from RX_EMPTY goes to RX_HOLDING, or straight to RX_FULL when the depth is 1. A push that reaches the depth goes from RX_HOLDING to RX_FULL. A pop moves RX_FULL back to RX_HOLDING. A pop that removes the last entry moves RX_HOLDING to RX_EMPTY. Any other combination of push and pop keeps the state. A range of ID words at the top of the 4 KiB window reads as fixed identification bytes.

Top module: `serial_host_regs`

## Requirements
- R1: After reset the flag word (word 6) reads 0x90, the level-select word (13) reads 0x12, the control word (12) reads 0x300, the raw status (15) reads 0, irq and tx_valid are low, and rx_ready is high.
- R2: Word offsets 0x3F8 to 0x3FF (byte 0xFE0 to 0xFFC) read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order, one byte per word.
- R3: A write to the data word (0) gives tx_valid high for one cycle with tx_byte equal to the low 8 bits of the write data, and it sets raw status bit 5 (TX).
- R4: With line-control bit 4 set, up to 16 bytes are accepted. rx_ready drops once 16 are held, and flag bit 6 (RX full) is then set.
- R5: With line-control bit 4 clear, only one byte is held, and rx_ready stays low until it is read.
- R6: Flag bit 4 (RX empty) clears when a byte is accepted and sets when a read removes the last byte. Raw status bit 4 (RX) sets when a byte brings the count from 0 to 1, and it clears when a read empties the buffer.
- R7: A data read returns the bytes in arrival order and clears flag bit 6.
- R8: A data read while the buffer is empty returns the entry at the read position and leaves the position and the count unchanged.
- R9: Writing word 17 clears each raw status bit whose write-data bit is 1 and leaves the others. A cleared RX bit is not set again until the buffer has emptied and refilled.
- R10: Word 16 reads raw status AND mask (word 14), and irq is high exactly when that value is nonzero.
- R11: With control-word bit 4 set, every accepted byte sets flag bit 6.
- R12: The storage words (8 low-power divisor, 9 integer divisor, 10 fractional divisor, 11 line control, 12 control, 13 level select, 18 DMA control) read back their written value truncated to 8, 16, 6, 8, 16, 6 and 3 bits. Writes to the flag word and to the raw status word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Receive buffer can take a byte |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Combined masked interrupt |

## Verification
Every result is registered once. Read data, tx_valid/tx_byte, the interrupt bits and the flag word are due on the first clock edge after the access or the accepted byte. rx_ready is combinational from the occupancy state, so it holds its new value from that same edge. The bench drives inputs on falling edges and samples on the falling edge that follows the active edge. It checks flags and status by a read issued in the next cycle. This keeps each check exactly one register stage behind its stimulus.

// File: rtl/serial_host_pkg.sv
package serial_host_pkg;

    localparam int WORD_W = 10;

    localparam logic [WORD_W-1:0] OFS_DATA   = 10'd0;
    localparam logic [WORD_W-1:0] OFS_FLAGS  = 10'd6;
    localparam logic [WORD_W-1:0] OFS_LPDIV  = 10'd8;
    localparam logic [WORD_W-1:0] OFS_IBAUD  = 10'd9;
    localparam logic [WORD_W-1:0] OFS_FBAUD  = 10'd10;
    localparam logic [WORD_W-1:0] OFS_LINE   = 10'd11;
    localparam logic [WORD_W-1:0] OFS_CTRL   = 10'd12;
    localparam logic [WORD_W-1:0] OFS_LEVEL  = 10'd13;
    localparam logic [WORD_W-1:0] OFS_MASK   = 10'd14;
    localparam logic [WORD_W-1:0] OFS_RAW    = 10'd15;
    localparam logic [WORD_W-1:0] OFS_MASKED = 10'd16;
    localparam logic [WORD_W-1:0] OFS_ICLR   = 10'd17;
    localparam logic [WORD_W-1:0] OFS_DMA    = 10'd18;
    localparam logic [6:0]        ID_PAGE    = 7'h7F;

    localparam int LPDIV_W = 8;
    localparam int IBAUD_W = 16;
    localparam int FBAUD_W = 6;
    localparam int LINE_W  = 8;
    localparam int CTRL_W  = 16;
    localparam int LEVEL_W = 6;
    localparam int MASK_W  = 11;
    localparam int DMA_W   = 3;

    localparam logic [CTRL_W-1:0]  CTRL_RST  = 16'h0300;
    localparam logic [LEVEL_W-1:0] LEVEL_RST = 6'h12;

    localparam int FLG_TX_EMPTY = 7;
    localparam int FLG_RX_FULL  = 6;
    localparam int FLG_TX_FULL  = 5;
    localparam int FLG_RX_EMPTY = 4;
    localparam int INT_TX       = 5;
    localparam int INT_RX       = 4;
    localparam int LINE_QUEUE   = 4;
    localparam int CTRL_HOLDFULL = 4;

    typedef enum logic [1:0] {
        RX_EMPTY,
        RX_HOLDING,
        RX_FULL
    } rx_state_e;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h11;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import serial_host_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deep_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              pop_req,
    output logic [BYTE_W-1:0] head_byte,
    output logic              is_empty,
    output logic              ev_first,
    output logic              ev_drained,
    output logic              ev_push,
    output logic              ev_top
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [AW-1:0]     rd_ptr, wr_ptr;
    logic [BYTE_W-1:0] slots [DEPTH];
    logic              push, pop;

    assign push = in_valid && in_ready;
    assign pop  = pop_req && (state_q != RX_EMPTY);
    assign cnt_d = cnt_q + CW'(push) - CW'(pop);

    // next occupancy state
    always_comb begin
        if (cnt_d == '0)
            state_d = RX_EMPTY;
        else if (cnt_d == CNT_MAX)
            state_d = RX_FULL;
        else
            state_d = RX_HOLDING;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs of the occupancy machine
    always_comb begin
        unique case (state_q)
            RX_EMPTY:   begin in_ready = 1'b1;                       is_empty = 1'b1; end
            RX_HOLDING: begin in_ready = deep_en;                    is_empty = 1'b0; end
            RX_FULL:    begin in_ready = 1'b0;                       is_empty = 1'b0; end
            default:    begin in_ready = 1'b0;                       is_empty = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
            if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    slots[i] <= '0;
                else if (push && (wr_ptr == AW'(i)))
                    slots[i] <= in_byte;
            end
        end
    endgenerate

    assign head_byte  = slots[rd_ptr];
    assign ev_push    = push;
    assign ev_first   = push && (cnt_d == CW'(1));
    assign ev_drained = pop && (cnt_d == '0);
    assign ev_top     = push && (cnt_d == CNT_MAX);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    assert_single_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !deep_en) |-> (state_q == RX_EMPTY));
    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && (state_q == RX_EMPTY) && !in_valid) |=> ((cnt_q == '0) && $stable(rd_ptr)));
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
    import serial_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   word,
    input  logic [31:0]         wdata,
    output logic [LPDIV_W-1:0]  lpdiv,
    output logic [IBAUD_W-1:0]  ibaud,
    output logic [FBAUD_W-1:0]  fbaud,
    output logic [LINE_W-1:0]   line,
    output logic [CTRL_W-1:0]   ctrl,
    output logic [LEVEL_W-1:0]  level,
    output logic [MASK_W-1:0]   mask,
    output logic [DMA_W-1:0]    dma
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lpdiv <= '0;
            ibaud <= '0;
            fbaud <= '0;
            line  <= '0;
            ctrl  <= CTRL_RST;
            level <= LEVEL_RST;
            mask  <= '0;
            dma   <= '0;
        end else if (wr_en) begin
            unique case (word)
                OFS_LPDIV: lpdiv <= wdata[LPDIV_W-1:0];
                OFS_IBAUD: ibaud <= wdata[IBAUD_W-1:0];
                OFS_FBAUD: fbaud <= wdata[FBAUD_W-1:0];
                OFS_LINE:  line  <= wdata[LINE_W-1:0];
                OFS_CTRL:  ctrl  <= wdata[CTRL_W-1:0];
                OFS_LEVEL: level <= wdata[LEVEL_W-1:0];
                OFS_MASK:  mask  <= wdata[MASK_W-1:0];
                OFS_DMA:   dma   <= wdata[DMA_W-1:0];
                default: ;
            endcase
        end
    end

    assert_ctrl_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (word == OFS_CTRL)) |=> $stable(ctrl));
endmodule

// File: rtl/serial_int_status.sv
module serial_int_status
    import serial_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_set,
    input  logic       rx_set,
    input  logic       rx_drop,
    input  logic       clr_en,
    input  logic [1:0] clr_bits,
    output logic       tx_int,
    output logic       rx_int
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_int <= 1'b0;
            rx_int <= 1'b0;
        end else begin
            if (tx_set)
                tx_int <= 1'b1;
            else if (clr_en && clr_bits[1])
                tx_int <= 1'b0;
            if (rx_set)
                rx_int <= 1'b1;
            else if (rx_drop || (clr_en && clr_bits[0]))
                rx_int <= 1'b0;
        end
    end

    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && (clr_bits == 2'b11) && !rx_set && !tx_set) |=> (!tx_int && !rx_int));
    assert_w1c_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && (clr_bits == 2'b01) && tx_int) |=> tx_int);
endmodule

// File: rtl/serial_host_regs.sv
module serial_host_regs
    import serial_host_pkg::*;
#(
    parameter int RX_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        irq
);
    logic [WORD_W-1:0]  word;
    logic               wr_hit, rd_hit, data_wr, data_rd, clr_wr;
    logic [LPDIV_W-1:0] lpdiv;
    logic [IBAUD_W-1:0] ibaud;
    logic [FBAUD_W-1:0] fbaud;
    logic [LINE_W-1:0]  line;
    logic [CTRL_W-1:0]  ctrl;
    logic [LEVEL_W-1:0] level;
    logic [MASK_W-1:0]  mask;
    logic [DMA_W-1:0]   dma;
    logic [7:0]         head_byte;
    logic               is_empty, ev_first, ev_drained, ev_push, ev_top;
    logic               tx_int, rx_int, rx_full_q;
    logic [31:0]        flags, raw, masked, rd_mux;

    assign word    = bus_addr[11:2];
    assign wr_hit  = bus_sel && bus_wr;
    assign rd_hit  = bus_sel && !bus_wr;
    assign data_wr = wr_hit && (word == OFS_DATA);
    assign data_rd = rd_hit && (word == OFS_DATA);
    assign clr_wr  = wr_hit && (word == OFS_ICLR);

    serial_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .word(word), .wdata(bus_wdata),
        .lpdiv(lpdiv), .ibaud(ibaud), .fbaud(fbaud), .line(line), .ctrl(ctrl),
        .level(level), .mask(mask), .dma(dma)
    );

    serial_rx_queue #(.DEPTH(RX_DEPTH), .BYTE_W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .deep_en(line[LINE_QUEUE]),
        .in_valid(rx_valid), .in_byte(rx_byte), .in_ready(rx_ready),
        .pop_req(data_rd), .head_byte(head_byte), .is_empty(is_empty),
        .ev_first(ev_first), .ev_drained(ev_drained), .ev_push(ev_push), .ev_top(ev_top)
    );

    serial_int_status u_int (
        .clk(clk), .rst_n(rst_n), .tx_set(data_wr), .rx_set(ev_first),
        .rx_drop(ev_drained), .clr_en(clr_wr),
        .clr_bits({bus_wdata[INT_TX], bus_wdata[INT_RX]}),
        .tx_int(tx_int), .rx_int(rx_int)
    );

    // sticky receive-full flag: an accept sets it, a data read clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_full_q <= 1'b0;
        else if (ev_push && (ev_top || ctrl[CTRL_HOLDFULL]))
            rx_full_q <= 1'b1;
        else if (data_rd)
            rx_full_q <= 1'b0;
    end

    always_comb begin
        flags = '0;
        flags[FLG_TX_EMPTY] = 1'b1;
        flags[FLG_TX_FULL]  = 1'b0;
        flags[FLG_RX_FULL]  = rx_full_q;
        flags[FLG_RX_EMPTY] = is_empty;
        raw = '0;
        raw[INT_TX] = tx_int;
        raw[INT_RX] = rx_int;
        masked = raw & 32'(mask);
    end

    assign irq = |masked;

    always_comb begin
        unique case (word)
            OFS_DATA:   rd_mux = 32'(head_byte);
            OFS_FLAGS:  rd_mux = flags;
            OFS_LPDIV:  rd_mux = 32'(lpdiv);
            OFS_IBAUD:  rd_mux = 32'(ibaud);
            OFS_FBAUD:  rd_mux = 32'(fbaud);
            OFS_LINE:   rd_mux = 32'(line);
            OFS_CTRL:   rd_mux = 32'(ctrl);
            OFS_LEVEL:  rd_mux = 32'(level);
            OFS_MASK:   rd_mux = 32'(mask);
            OFS_RAW:    rd_mux = raw;
            OFS_MASKED: rd_mux = masked;
            OFS_DMA:    rd_mux = 32'(dma);
            default:    rd_mux = (word[9:3] == ID_PAGE) ? 32'(id_byte(word[2:0])) : '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            tx_valid   <= 1'b0;
            tx_byte    <= '0;
        end else begin
            bus_rvalid <= rd_hit;
            if (rd_hit) bus_rdata <= rd_mux;
            tx_valid <= data_wr;
            if (data_wr) tx_byte <= bus_wdata[7:0];
        end
    end

    assert_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (tx_valid && (tx_byte == $past(bus_wdata[7:0]))));
    assert_tx_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> raw[INT_TX]);
    assert_read_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> bus_rvalid);
    assert_full_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_top && !data_rd) |=> (flags[FLG_RX_FULL] && !rx_ready));
endmodule

// File: tb/serial_host_regs_test.sv
module serial_host_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    serial_host_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    localparam logic [11:0] A_DATA = 12'h000, A_FLAGS = 12'h018, A_LINE = 12'h02C,
        A_CTRL = 12'h030, A_LEVEL = 12'h034, A_MASK = 12'h038, A_RAW = 12'h03C,
        A_MASKED = 12'h040, A_ICLR = 12'h044;

    // address, write data, expected read-back (R12)
    localparam logic [75:0] VECS [0:8] = '{
        {12'h020, 32'hFFFF_FFAB, 32'h0000_00AB},
        {12'h024, 32'h1234_5678, 32'h0000_5678},
        {12'h028, 32'h0000_00FF, 32'h0000_003F},
        {12'h02C, 32'h0000_01FF, 32'h0000_00FF},
        {12'h034, 32'h0000_00FF, 32'h0000_003F},
        {12'h048, 32'h0000_00FF, 32'h0000_0007},
        {12'h030, 32'hFFFF_0300, 32'h0000_0300},
        {12'h03C, 32'h0000_00FF, 32'h0000_0000},
        {12'h018, 32'h0000_0000, 32'h0000_0090}
    };

    localparam logic [7:0] ID_EXP [0:7] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, output logic took);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        #0.1 took = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        logic took;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        check("R1 rx_ready", 32'(rx_ready), 1);
        bus_read(A_FLAGS, r);  check("R1 flags", r, 32'h90);
        bus_read(A_LEVEL, r);  check("R1 level", r, 32'h12);
        bus_read(A_CTRL, r);   check("R1 ctrl", r, 32'h300);
        bus_read(A_RAW, r);    check("R1 raw", r, 0);

        // R12 storage vectors
        for (int i = 0; i < 9; i++) begin
            bus_write(VECS[i][75:64], VECS[i][63:32]);
            bus_read(VECS[i][75:64], r);
            check("R12 storage", r, VECS[i][31:0]);
        end

        // R2 ID words
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(4 * i), r);
            check("R2 id", r, 32'(ID_EXP[i]));
        end

        // R3 transmit
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = 32'h1A5;
        @(negedge clk);
        bus_sel = 1'b0;
        check("R3 tx_valid", 32'(tx_valid), 1);
        check("R3 tx_byte", 32'(tx_byte), 32'hA5);
        @(negedge clk);
        check("R3 tx pulse ends", 32'(tx_valid), 0);
        bus_read(A_RAW, r); check("R3 raw tx", r, 32'h20);
        check("R10 irq masked off", 32'(irq), 0);
        bus_write(A_MASK, 32'h20);
        check("R10 irq on", 32'(irq), 1);
        bus_read(A_MASKED, r); check("R10 masked", r, 32'h20);
        bus_write(A_ICLR, 32'h10);
        bus_read(A_RAW, r); check("R9 keep tx", r, 32'h20);
        bus_write(A_ICLR, 32'h20);
        bus_read(A_RAW, r); check("R9 clear tx", r, 0);
        check("R10 irq off", 32'(irq), 0);
        bus_write(A_MASK, 0);

        // R5 single slot
        bus_write(A_LINE, 32'h00);
        push(8'h11, took); check("R5 first accepted", 32'(took), 1);
        check("R5 ready low", 32'(rx_ready), 0);
        push(8'h22, took); check("R5 second refused", 32'(took), 0);
        bus_read(A_FLAGS, r); check("R6 rx empty clear", r, 32'h80);
        bus_read(A_RAW, r); check("R6 rx int set", r, 32'h10);
        bus_read(A_DATA, r); check("R5 data", r, 32'h11);
        bus_read(A_FLAGS, r); check("R6 rx empty set", r, 32'h90);
        bus_read(A_RAW, r); check("R6 rx int clear", r, 0);

        // R8 read while empty, then show the read position stayed
        bus_read(A_DATA, r); check("R8 idle read", r, 0);
        bus_read(A_FLAGS, r); check("R8 flags", r, 32'h90);
        push(8'h33, took);
        bus_read(A_DATA, r); check("R8 position kept", r, 32'h33);

        // R4 deep queue
        bus_write(A_LINE, 32'h10);
        for (int i = 0; i < 16; i++) begin
            push(8'h40 + 8'(i), took);
            check("R4 accept", 32'(took), 1);
        end
        check("R4 ready low at 16", 32'(rx_ready), 0);
        push(8'hEE, took); check("R4 17th refused", 32'(took), 0);
        bus_read(A_FLAGS, r); check("R4 full flag", r, 32'hC0);
        bus_read(A_RAW, r); check("R6 rx int", r, 32'h10);
        bus_write(A_ICLR, 32'h10);
        bus_read(A_RAW, r); check("R9 rx cleared", r, 0);
        for (int i = 0; i < 16; i++) begin
            bus_read(A_DATA, r);
            check("R7 order", r, 32'h40 + 32'(i));
            if (i == 0) begin
                bus_read(A_FLAGS, r); check("R7 full flag cleared", r, 32'h80);
            end
        end
        bus_read(A_RAW, r); check("R9 not reasserted", r, 0);
        bus_read(A_FLAGS, r); check("R6 drained", r, 32'h90);
        push(8'h5A, took);
        bus_read(A_RAW, r); check("R9 refill sets rx", r, 32'h10);

        // R10 rx interrupt through mask
        bus_write(A_MASK, 32'h10);
        check("R10 irq rx", 32'(irq), 1);
        bus_read(A_DATA, r); check("R7 data", r, 32'h5A);
        check("R10 irq drops", 32'(irq), 0);
        bus_write(A_MASK, 0);

        // R11 control bit holds full flag on any accept
        bus_write(A_CTRL, 32'h310);
        push(8'h77, took);
        bus_read(A_FLAGS, r); check("R11 full on accept", r, 32'hC0);
        bus_read(A_DATA, r); check("R11 data", r, 32'h77);
        bus_read(A_FLAGS, r); check("R11 after read", r, 32'h90);

        finish_run();
    end
endmodule